// File: doc/BRIEF.md
# Variable-Width Queued SPI Master

This block is an SPI master that a host drives through a small word-wide register interface. The host writes transmit words into a four-entry queue. Each word carries its own shift length of 1 to 24 bits, and its data sits left-aligned so that the first bit out is bit 23. A shift engine pops the words one at a time. It runs the serial clock at the system clock divided by 2×(speed+1) and shifts the data out MSB first. At the same time it gathers the incoming bits, right-aligned, into a four-entry receive queue.

The host chooses, for each word, whether it ends a transfer. A word written to the hold register keeps chip select asserted so the next word follows in the same frame. A word written to the data register is the final word of the frame. After every word the serial clock idles for two periods. After a final word, chip select goes high for a programmable time before the next frame can start. Two interrupt sources, selected in the second control register, tell the host when the transmit queue has drained or when the engine has gone idle.

Top module: `vw_spi_master`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0 and irq is 0, and the status register (offset 0x08) reads 0x0000_0280, which means both queues are empty, nothing is busy and every level is zero.
- R2: Each serial clock half-period lasts speed+1 system cycles, where speed is control-0 bits 31:20. While the engine is idle, sclk rests at the polarity bit, control-0 bit 7.
- R3: Each word produces exactly its length in sclk pulses, shifted out MSB first starting at bit 23. The length is chosen as follows:
  - With control-0 bit 14 set, the length is bits 31:24 of the written word. A value of 0 shifts 1 bit, and values above 24 shift 24 bits.
  - With bit 14 clear, the length is control-0 bits 5:0, clamped the same way.
- R4: Received bits are right-aligned, so the last bit received lands in bit 0. The receive register is cleared when each word starts, unless keep-input (control-1 bit 0) is set, in which case new bits accumulate onto the previous contents.
- R5: Input is sampled on the rising sclk edge when control-0 bit 10 is 1, and on the falling edge when it is 0, for either clock polarity.
- R6: A word written to offset 0x30 keeps cs_n low after it. When the next word is already queued, sclk stays quiet for 5×(speed+1)+1 cycles between the two words, which covers two idle periods plus the restart.
- R7: A word written to offset 0x20 ends the frame. If another word is waiting, cs_n stays high for exactly 2×(1+H)×(speed+1)+1 cycles, where H is control-1 bits 10:8.
- R8: A write to a full transmit queue is dropped. The transmit level never exceeds 4, and the full flag is status bit 10.
- R9: Reading offset 0x20 pops the oldest received word. Reading offset 0x0C returns the same word without popping it. Either read returns 0 when the receive queue is empty.
- R10: The status register holds these fields:
  - transmit level in bits 31:24 and receive level in bits 23:16;
  - transmit-full in bit 10, transmit-empty in bit 9, receive-full in bit 8 and receive-empty in bit 7;
  - busy in bit 6, which stays high from the pop of a word through its idle clocks and chip-select time;
  - remaining bit count in bits 5:0.
- R11: Writing control-0 with bit 9 set empties both queues.
- R12: irq goes high one cycle after either of these holds: transmit-empty with control-1 bit 7 set, or not busy and transmit-empty with control-1 bit 6 set. Writing 0 to control-1 clears it.
- R13: No word starts while the enable bit, control-0 bit 11, is 0. Queued words wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |
| irq | output | 1 | Interrupt request |

## Verification
The main path is driven with several kinds of stimulus, and each one separates a different class of fault:
- A full 24-bit word sent through a straight loopback shows whether bit order and alignment are right.
- The same word sent through an inverted loopback shows the received bits come from the input pin and not from a copy of the transmit register.
- Short, zero and oversized length fields show whether the length decode and clamping work. The fixed-length mode, fed a word with a nonzero top byte, shows which length source is actually used.
- Each clock polarity and sampling edge is run separately.
- A hold-then-final pair and a final-then-final pair are timed cycle by cycle, which distinguishes the frame-continue path from the chip-select high time.

// File: rtl/vw_spi_pkg.sv
package vw_spi_pkg;
  localparam logic [7:0] OFS_CTRL0 = 8'h00;
  localparam logic [7:0] OFS_CTRL1 = 8'h04;
  localparam logic [7:0] OFS_STAT  = 8'h08;
  localparam logic [7:0] OFS_PEEK  = 8'h0C;
  localparam logic [7:0] OFS_DATA  = 8'h20;
  localparam logic [7:0] OFS_HOLD  = 8'h30;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP,
    ST_CSHI
  } eng_state_t;
endpackage

// File: rtl/vw_spi_fifo.sv
module vw_spi_fifo #(
  parameter int W     = 30,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign level   = cnt;
  assign rdata   = mem[rp];

  // storage kept free of reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/vw_spi_engine.sv
module vw_spi_engine
  import vw_spi_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int LEN_W  = 5,
  parameter int SPD_W  = 12,
  parameter int CSH_W  = 3,
  localparam int ENT_W = 1 + LEN_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cpol,
  input  logic              in_rising,
  input  logic              keep_in,
  input  logic [SPD_W-1:0]  speed,
  input  logic [CSH_W-1:0]  cs_hi,
  input  logic              tx_empty,
  input  logic [ENT_W-1:0]  tx_entry,
  input  logic              miso,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic [LEN_W-1:0]  bits_left,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n
);
  eng_state_t        st;
  logic [SPD_W-1:0]  div;
  logic              tick, phase, hold_q, sample_lead, start;
  logic [DATA_W-1:0] tsh, rsh;
  logic [LEN_W-1:0]  left;
  logic [CSH_W+1:0]  wait_n;

  assign tick        = (div == speed);
  assign sample_lead = in_rising ^ cpol;  // rising edge leads when polarity is 0
  assign start       = (st == ST_IDLE) && en && !tx_empty;
  assign tx_pop      = start;
  assign busy        = (st != ST_IDLE);
  assign bits_left   = left;
  assign mosi        = tsh[DATA_W-1];
  assign rx_data     = rsh;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      div     <= '0;
      phase   <= 1'b0;
      hold_q  <= 1'b0;
      tsh     <= '0;
      rsh     <= '0;
      left    <= '0;
      wait_n  <= '0;
      sclk    <= 1'b0;
      cs_n    <= 1'b1;
      rx_push <= 1'b0;
    end else begin
      rx_push <= 1'b0;
      if (st != ST_IDLE) div <= tick ? '0 : div + 1'b1;
      case (st)
        ST_IDLE: begin
          sclk <= cpol;
          if (start) begin
            st     <= ST_SHIFT;
            div    <= '0;
            phase  <= 1'b0;
            cs_n   <= 1'b0;
            hold_q <= tx_entry[DATA_W+LEN_W];
            left   <= tx_entry[DATA_W +: LEN_W];
            tsh    <= tx_entry[DATA_W-1:0];
            if (!keep_in) rsh <= '0;
          end
        end
        ST_SHIFT: if (tick) begin
          phase <= ~phase;
          sclk  <= phase ? cpol : ~cpol;
          if (phase != sample_lead) rsh <= {rsh[DATA_W-2:0], miso};
          if (phase) begin
            tsh  <= {tsh[DATA_W-2:0], 1'b0};
            left <= left - 1'b1;
            if (left == LEN_W'(1)) begin
              st     <= ST_GAP;
              wait_n <= (CSH_W+2)'(3);  // four half periods
            end
          end
        end
        ST_GAP: if (tick) begin
          wait_n <= wait_n - 1'b1;
          if (wait_n == '0) begin
            rx_push <= 1'b1;
            if (hold_q) st <= ST_IDLE;
            else begin
              st     <= ST_CSHI;
              cs_n   <= 1'b1;
              wait_n <= {1'b0, cs_hi, 1'b1};  // 2*(1+H) half periods
            end
          end
        end
        ST_CSHI: if (tick) begin
          wait_n <= wait_n - 1'b1;
          if (wait_n == '0) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vw_spi_master.sv
module vw_spi_master
  import vw_spi_pkg::*;
#(
  parameter int DATA_W     = 24,
  parameter int FIFO_DEPTH = 4,
  parameter int SPD_W      = 12,
  parameter int CSH_W      = 3,
  localparam int LEN_W     = $clog2(DATA_W + 1),
  localparam int ENT_W     = 1 + LEN_W + DATA_W,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n,
  output logic        irq
);
  logic [31:0]       c0;
  logic [10:0]       c1;
  logic              cpol_w, busy_w, tx_empty_w, tx_full_w, rx_empty, rx_full;
  logic              wr_tx, tx_pop, rx_push, rx_pop, clr_fifo, idle_ie, txe_ie;
  logic [CW-1:0]     tx_lvl, rx_lvl;
  logic [ENT_W-1:0]  tx_in, tx_out;
  logic [DATA_W-1:0] rx_in, rx_out;
  logic [LEN_W-1:0]  bits_left, eff_len;
  logic [7:0]        raw_len;
  logic [31:0]       rd_next;

  assign cpol_w   = c0[7];
  assign idle_ie  = c1[6];
  assign txe_ie   = c1[7];
  assign wr_tx    = reg_wr && (reg_addr == OFS_DATA || reg_addr == OFS_HOLD);
  assign clr_fifo = reg_wr && (reg_addr == OFS_CTRL0) && reg_wdata[9];
  assign rx_pop   = reg_rd && (reg_addr == OFS_DATA);

  // shift length is resolved once, at queue time
  always_comb begin
    raw_len = c0[14] ? reg_wdata[31:24] : {2'b00, c0[5:0]};
    if (raw_len == 8'd0)             eff_len = LEN_W'(1);
    else if (raw_len > 8'(DATA_W))   eff_len = LEN_W'(DATA_W);
    else                             eff_len = raw_len[LEN_W-1:0];
  end
  assign tx_in = {reg_addr == OFS_HOLD, eff_len, reg_wdata[DATA_W-1:0]};

  vw_spi_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) i_txq (
    .clk(clk), .rst(rst), .clr(clr_fifo), .push(wr_tx), .wdata(tx_in),
    .pop(tx_pop), .rdata(tx_out), .level(tx_lvl), .full(tx_full_w), .empty(tx_empty_w));

  vw_spi_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_rxq (
    .clk(clk), .rst(rst), .clr(clr_fifo), .push(rx_push), .wdata(rx_in),
    .pop(rx_pop), .rdata(rx_out), .level(rx_lvl), .full(rx_full), .empty(rx_empty));

  vw_spi_engine #(.DATA_W(DATA_W), .LEN_W(LEN_W), .SPD_W(SPD_W), .CSH_W(CSH_W)) i_eng (
    .clk(clk), .rst(rst), .en(c0[11]), .cpol(cpol_w), .in_rising(c0[10]),
    .keep_in(c1[0]), .speed(c0[31:32-SPD_W]), .cs_hi(c1[8 +: CSH_W]),
    .tx_empty(tx_empty_w), .tx_entry(tx_out), .miso(miso), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_data(rx_in), .busy(busy_w), .bits_left(bits_left),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n));

  always_comb begin
    case (reg_addr)
      OFS_CTRL0: rd_next = c0;
      OFS_CTRL1: rd_next = {21'd0, c1};
      OFS_STAT:  rd_next = {8'(tx_lvl), 8'(rx_lvl), 5'd0, tx_full_w, tx_empty_w,
                            rx_full, rx_empty, busy_w, 6'(bits_left)};
      OFS_PEEK, OFS_DATA:
                 rd_next = rx_empty ? 32'd0 : {{(32-DATA_W){1'b0}}, rx_out};
      default:   rd_next = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c0        <= '0;
      c1        <= '0;
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == OFS_CTRL0) c0 <= reg_wdata & ~32'h0000_0200;
      if (reg_wr && reg_addr == OFS_CTRL1) c1 <= reg_wdata[10:0];
      if (reg_rd) reg_rdata <= rd_next;
      irq <= (txe_ie && tx_empty_w) || (idle_ie && !busy_w && tx_empty_w);
    end
  end
endmodule

// File: rtl/vw_spi_master_checks.sv
module vw_spi_master_checks #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          sclk,
  input logic          cs_n,
  input logic          irq,
  input logic          cpol,
  input logic          busy,
  input logic          tx_empty,
  input logic          tx_full,
  input logic [CW-1:0] tx_lvl,
  input logic          wr_tx,
  input logic          tx_pop,
  input logic          clr,
  input logic          idle_ie
);
  AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> (sclk == $past(cpol)));                          // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    tx_lvl <= CW'(DEPTH));                                                       // R8
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (tx_full && wr_tx && !tx_pop && !clr) |=> tx_full);                          // R8
  AST_CS_HIGH_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cs_n && busy) |-> $stable(sclk));                                           // R7
  AST_IDLE_IRQ: assert property (@(posedge clk) disable iff (rst)
    (idle_ie && !busy && tx_empty) |=> irq);                                     // R12
endmodule

bind vw_spi_master vw_spi_master_checks #(.DEPTH(FIFO_DEPTH), .CW(CW)) i_checks (
  .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .irq(irq), .cpol(cpol_w),
  .busy(busy_w), .tx_empty(tx_empty_w), .tx_full(tx_full_w), .tx_lvl(tx_lvl),
  .wr_tx(wr_tx), .tx_pop(tx_pop), .clr(clr_fifo), .idle_ie(idle_ie));

// File: tb/test_vw_spi_master.sv
module test_vw_spi_master;
  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0, reg_rdata;
  logic sclk, mosi, miso, cs_n, irq;
  logic inv = 1'b0;
  int total = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];

  assign miso = inv ? ~mosi : mosi;
  always #5 clk = ~clk;

  vw_spi_master i_vw_spi_master (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n), .irq(irq));

  // line monitor
  logic prev_sclk = 1'b0, prev_cs = 1'b1;
  int tog = 0, since = 0, min_gap = 0, max_gap = 0, falls = 0, rises = 0, hi_run = 0, last_hi = 0;
  bit have = 1'b0;
  always @(negedge clk) begin
    if (sclk !== prev_sclk) begin
      tog++;
      if (have) begin
        if (min_gap == 0 || since + 1 < min_gap) min_gap = since + 1;
        if (since + 1 > max_gap) max_gap = since + 1;
      end
      have = 1'b1;
      since = 0;
    end else since++;
    if (cs_n) hi_run++;
    if (prev_cs && !cs_n) begin falls++; last_hi = hi_run; hi_run = 0; end
    if (!prev_cs && cs_n) rises++;
    prev_sclk = sclk;
    prev_cs = cs_n;
  end

  task automatic clr_stats();
    repeat (2) @(negedge clk);
    tog = 0; since = 0; min_gap = 0; max_gap = 0; falls = 0; rises = 0; last_hi = 0; have = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  function automatic logic [31:0] c0v(input int spd, input bit en, input bit inr,
                                      input bit pol, input bit vw, input int fl);
    return (32'(spd) << 20) | (32'(en) << 11) | (32'(inr) << 10) | (32'(vw) << 14)
         | (32'(pol) << 7) | 32'(fl);
  endfunction

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(8'h08, s);
      if (!s[6] && s[9]) break;
    end
  endtask

  // scoreboard: driver side pushes, checker side pops against the design
  task automatic exp_rx(input logic [31:0] v);
    exp_q.push_back(v);
  endtask

  task automatic check_rx(input string req);
    logic [31:0] d, e;
    e = (exp_q.size() != 0) ? exp_q.pop_front() : 32'hDEAD_BEEF;
    rd(8'h20, d);
    chk(req, d, e);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", 32'(cs_n), 32'd1);
    chk("R1 sclk", 32'(sclk), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    rd(8'h08, s);
    chk("R1 status", s, 32'h0000_0280);

    // R13 disabled engine holds queued word
    wr(8'h00, c0v(3, 0, 1, 0, 1, 0));
    clr_stats();
    wr(8'h20, 32'h18A5C33C);
    repeat (40) @(negedge clk);
    chk("R13 cs_n idle", 32'(cs_n), 32'd1);
    chk("R13 no sclk", 32'(tog), 32'd0);
    rd(8'h08, s);
    chk("R10 tx level", 32'(s[31:24]), 32'd1);
    // R11 clear
    wr(8'h00, c0v(3, 0, 1, 0, 1, 0) | 32'h200);
    rd(8'h08, s);
    chk("R11 tx cleared", 32'(s[31:24]), 32'd0);

    // main 24-bit loopback, speed 3
    wr(8'h00, c0v(3, 1, 1, 0, 1, 0));
    clr_stats();
    wr(8'h20, 32'h18A5C33C);
    repeat (6) @(negedge clk);
    rd(8'h08, s);
    chk("R10 busy bit", 32'(s[6]), 32'd1);
    wait_done();
    chk("R2 half period", 32'(min_gap), 32'd4);
    chk("R3 24 bit pulses", 32'(tog), 32'd48);
    exp_rx(32'h00A5C33C);
    check_rx("R4 loopback 24");

    // inverted input, 8-bit word
    inv = 1'b1;
    clr_stats();
    wr(8'h20, 32'h085A0000);
    wait_done();
    chk("R3 8 bit pulses", 32'(tog), 32'd16);
    exp_rx(32'h000000A5);
    check_rx("R4 inverted right aligned");
    inv = 1'b0;

    // length clamps
    clr_stats();
    wr(8'h20, 32'h00800000);
    wait_done();
    chk("R3 zero length", 32'(tog), 32'd2);
    exp_rx(32'h00000001);
    check_rx("R3 zero length data");
    clr_stats();
    wr(8'h20, 32'h28F0F0F0);
    wait_done();
    chk("R3 clamp 24", 32'(tog), 32'd48);
    exp_rx(32'h00F0F0F0);
    check_rx("R3 clamp data");

    // fixed length mode, top byte ignored
    wr(8'h00, c0v(3, 1, 1, 0, 0, 12));
    clr_stats();
    wr(8'h20, 32'hFFABC000);
    wait_done();
    chk("R3 fixed pulses", 32'(tog), 32'd24);
    exp_rx(32'h00000ABC);
    check_rx("R3 fixed data");

    // polarity 1, sample on rising (trailing) edge
    wr(8'h00, c0v(2, 1, 1, 1, 1, 0));
    clr_stats();
    chk("R2 idle high", 32'(sclk), 32'd1);
    wr(8'h20, 32'h10123400);
    wait_done();
    chk("R2 half period cpol1", 32'(min_gap), 32'd3);
    exp_rx(32'h00001234);
    check_rx("R5 cpol1 rising");
    // polarity 0, sample on falling edge
    wr(8'h00, c0v(2, 1, 0, 0, 1, 0));
    clr_stats();
    wr(8'h20, 32'h10BEEF00);
    wait_done();
    exp_rx(32'h0000BEEF);
    check_rx("R5 cpol0 falling");

    // R6 hold then final
    wr(8'h00, c0v(1, 0, 1, 0, 1, 0));
    wr(8'h30, 32'h08C30000);
    wr(8'h20, 32'h083C0000);
    clr_stats();
    wr(8'h00, c0v(1, 1, 1, 0, 1, 0));
    wait_done();
    chk("R6 one frame fall", 32'(falls), 32'd1);
    chk("R6 one frame rise", 32'(rises), 32'd1);
    chk("R6 pulses", 32'(tog), 32'd32);
    chk("R6 quiet between", 32'(max_gap), 32'd11);
    exp_rx(32'h000000C3);
    exp_rx(32'h0000003C);
    check_rx("R6 first");
    check_rx("R6 second");

    // R7 chip-select high time, H=2, speed 1
    wr(8'h04, 32'h00000200);
    wr(8'h00, c0v(1, 0, 1, 0, 1, 0));
    wr(8'h20, 32'h08110000);
    wr(8'h20, 32'h08220000);
    clr_stats();
    wr(8'h00, c0v(1, 1, 1, 0, 1, 0));
    wait_done();
    chk("R7 frames", 32'(falls), 32'd2);
    chk("R7 cs high cycles", 32'(last_hi), 32'd13);
    exp_rx(32'h00000011);
    exp_rx(32'h00000022);
    check_rx("R7 first");
    check_rx("R7 second");

    // keep-input accumulation
    wr(8'h04, 32'h0);
    wr(8'h20, 32'h08AB0000);
    wait_done();
    wr(8'h04, 32'h1);
    wr(8'h20, 32'h08CD0000);
    wait_done();
    exp_rx(32'h000000AB);
    exp_rx(32'h0000ABCD);
    check_rx("R4 keep off");
    check_rx("R4 keep accumulate");
    wr(8'h04, 32'h0);

    // R9 peek and pop
    wr(8'h20, 32'h08770000);
    wr(8'h20, 32'h08880000);
    wait_done();
    rd(8'h08, s);
    chk("R10 rx level", 32'(s[23:16]), 32'd2);
    rd(8'h0C, s);
    chk("R9 peek", s, 32'h77);
    rd(8'h0C, s);
    chk("R9 peek again", s, 32'h77);
    exp_rx(32'h77);
    check_rx("R9 pop first");
    rd(8'h08, s);
    chk("R9 level after pop", 32'(s[23:16]), 32'd1);
    exp_rx(32'h88);
    check_rx("R9 pop second");
    exp_rx(32'h0);
    check_rx("R9 empty pop");

    // R11 clear receive side
    wr(8'h20, 32'h08550000);
    wait_done();
    wr(8'h00, c0v(1, 1, 1, 0, 1, 0) | 32'h200);
    rd(8'h08, s);
    chk("R11 rx cleared", {s[23:16], 7'd0, s[7]}, {8'd0, 7'd0, 1'b1});

    // R8 full queue drops writes
    wr(8'h00, c0v(1, 0, 1, 0, 1, 0));
    for (int i = 0; i < 5; i++) wr(8'h20, 32'h08000000 | (32'(i) << 16));
    rd(8'h08, s);
    chk("R8 level capped", 32'(s[31:24]), 32'd4);
    chk("R8 full flag", 32'(s[10]), 32'd1);

    // R12 interrupts
    wr(8'h04, 32'h80);
    repeat (2) @(negedge clk);
    chk("R12 txe irq low", 32'(irq), 32'd0);
    wr(8'h00, c0v(1, 0, 1, 0, 1, 0) | 32'h200);
    repeat (2) @(negedge clk);
    chk("R12 txe irq high", 32'(irq), 32'd1);
    wr(8'h04, 32'h0);
    repeat (2) @(negedge clk);
    chk("R12 irq cleared", 32'(irq), 32'd0);
    wr(8'h04, 32'h40);
    repeat (2) @(negedge clk);
    chk("R12 idle irq", 32'(irq), 32'd1);
    wr(8'h20, 32'h10000000);
    repeat (2) @(negedge clk);
    chk("R12 irq low while queued", 32'(irq), 32'd0);
    wr(8'h00, c0v(1, 1, 1, 0, 1, 0));
    repeat (4) @(negedge clk);
    chk("R12 irq low while busy", 32'(irq), 32'd0);
    wait_done();
    repeat (2) @(negedge clk);
    chk("R12 irq after idle", 32'(irq), 32'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule